// File: doc/BRIEF.md
# SPI Flash Command Engine

This block is the serial master inside a bridge that lets a host reach a SPI flash through a small register window. Software fills a five-byte transmit area with an opcode, address and data. It then writes one control byte. That byte chooses the clock rate, the number of bytes to send and the number of response bytes to capture. The engine drives chip select low, shifts the bytes out most-significant bit first in SPI mode 0, and captures the response bytes into three receive registers. A busy flag in the control byte stays at 1 until the transaction has ended, so software polls it.

The control byte can also arm a page-program session. In that mode each write to a data port sends one byte. The first such write is preceded by the opcode held in the first transmit register. Chip select stays low across all page bytes and rises after the last one. Large flash devices, whose upper regions cannot be reached by the memory-mapped path, are read and written entirely through these command cycles.

Top module: `spi_flash_cmd_engine`

## Requirements
- R1: After reset, the control byte reads 0x00, chip select is high, SCK is low, and the receive registers read 0x00.
- R2: The control byte is laid out as follows: bit 7 is busy (read only), bits 6:4 are the mode, bits 3:2 are the read count, and bits 1:0 are the write code. Mode 5 starts a command at the fast rate and mode 4 starts one at the slow rate. Busy reads 1 from the cycle after the starting write until the transaction ends. A read of offset 0 returns the accepted bits 6:0 below the busy bit.
- R3: Write code 0, 1, 2 and 3 sends 1, 2, 4 and 5 bytes respectively, taken in order from offsets 1 to 5. Each byte goes out MSB first; MOSI changes while SCK is low and is sampled on the rising edge. Offsets 1 to 5 read back the values written to them.
- R4: After the sent bytes, the engine clocks out the number of response bytes given by the read count (0 to 3), with MOSI held low. The received bytes are stored at offsets 6, 7 and 8 in arrival order.
- R5: The SCK period is 2*FAST_HALF clock cycles at the fast rate and 2*SLOW_HALF at the slow rate (6 and 12 by default).
- R6: Chip select is low from before the first SCK edge of a transaction until after its last edge. It is high between transactions, and SCK never pulses while chip select is high.
- R7: While busy is 1, writes to offset 0 and to offsets 1 to 5 have no effect.
- R8: Mode 3 (fast) or mode 2 (slow) arms a page session without any bus activity. The first write to offset 9 lowers chip select and sends the opcode from offset 1 and then that byte. Each later write sends one byte. Chip select stays low until PAGE_BYTES data bytes have gone out, then rises, and the session disarms.
- R9: A write to offset 9 has no effect when no page session is armed, or while busy is 1.
- R10: A control write made between the bytes of an open page session only ends the session. Chip select rises, busy stays 0, and later offset-9 writes are ignored.
- R11: Modes 0, 1, 6 and 7 start nothing and disarm any page session. Writing 0x20 arms a slow page session and leaves busy 0 and chip select high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write offset |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read offset |
| rd_data | output | 8 | Register read data (combinational) |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
Busy is due in the cycle right after the starting write. The bench reads the control byte at the next falling clock edge and expects bit 7 set. Serial bytes are spaced by the SCK half period plus a fixed hand-off of a few cycles, so the bench does not count cycles to byte boundaries. A scoreboard slave compares every byte and each rising-edge spacing as the edges arrive. Receive registers are written on the same edge that clears busy, so the bench reads them only after polling has seen busy at 0.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

  localparam int NUM_TX = 5;
  localparam int NUM_RX = 3;

  localparam logic [3:0] OFS_CTRL  = 4'd0;
  localparam logic [3:0] OFS_TX0   = 4'd1;
  localparam logic [3:0] OFS_RX0   = 4'd6;
  localparam logic [3:0] OFS_PDATA = 4'd9;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_CMD,
    SQ_RESP,
    SQ_POP,
    SQ_PDATA,
    SQ_PWAIT
  } sq_state_t;

  // write code -> number of bytes sent
  function automatic logic [2:0] wr_count(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      2'd2:    return 3'd4;
      default: return 3'd5;
    endcase
  endfunction

  function automatic logic is_cmd_mode(input logic [2:0] m);
    return (m == 3'd4) || (m == 3'd5);
  endfunction

  function automatic logic is_page_mode(input logic [2:0] m);
    return (m == 3'd2) || (m == 3'd3);
  endfunction

endpackage

// File: rtl/spi_eng_clkgen.sv
module spi_eng_clkgen #(
  parameter int FAST_HALF = 3,
  parameter int SLOW_HALF = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic fast,
  output logic tick
);
  localparam int MAXH = (FAST_HALF > SLOW_HALF) ? FAST_HALF : SLOW_HALF;
  localparam int CW   = $clog2(MAXH + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  assign lim  = fast ? CW'(FAST_HALF - 1) : CW'(SLOW_HALF - 1);
  assign tick = run && (cnt_q == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!run)    cnt_q <= '0;
    else if (tick)    cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  assert_half_period_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= lim));
  assert_restart_from_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (cnt_q == '0));

endmodule

// File: rtl/spi_eng_shifter.sv
module spi_eng_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       tick,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       active,
  output logic       done,
  output logic [7:0] rx_byte
);
  logic [7:0] sh_q, rx_q;
  logic [2:0] bit_q;
  logic       sck_q, act_q, done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0; rx_q <= '0; bit_q <= '0;
      sck_q <= 1'b0; act_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start && !act_q) begin
        act_q <= 1'b1;
        sh_q  <= tx_byte;
        bit_q <= '0;
        sck_q <= 1'b0;
      end else if (act_q && tick) begin
        if (!sck_q) begin
          sck_q <= 1'b1;
          rx_q  <= {rx_q[6:0], miso};
        end else begin
          sck_q <= 1'b0;
          if (bit_q == 3'd7) begin
            act_q  <= 1'b0;
            done_q <= 1'b1;
          end else begin
            bit_q <= bit_q + 3'd1;
            sh_q  <= {sh_q[6:0], 1'b0};
          end
        end
      end
    end
  end

  assign sck     = sck_q;
  assign mosi    = act_q & sh_q[7];
  assign active  = act_q;
  assign done    = done_q;
  assign rx_byte = rx_q;

  assert_sck_rests_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !act_q |-> !sck_q);
  assert_start_only_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !act_q);
  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

endmodule

// File: rtl/spi_eng_seq.sv
module spi_eng_seq
  import spi_eng_pkg::*;
#(
  parameter int PAGE_BYTES = 256
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctrl_wr,
  input  logic                pdata_wr,
  input  logic [7:0]          wr_val,
  input  logic [NUM_TX*8-1:0] tx_flat,
  input  logic                sh_done,
  input  logic [7:0]          sh_rx,
  output logic                sh_start,
  output logic [7:0]          sh_byte,
  output logic                fast,
  output logic                busy,
  output logic                cs_n,
  output logic [6:0]          ctrl_bits,
  output logic                rx_we,
  output logic [1:0]          rx_idx,
  output logic [7:0]          rx_byte
);
  localparam int PCW = $clog2(PAGE_BYTES + 1);

  sq_state_t      st_q;
  logic [2:0]     idx_q, nwr_q, idx_n;
  logic [1:0]     nrd_q;
  logic [PCW-1:0] pg_cnt_q;
  logic [7:0]     pend_q;
  logic [6:0]     ctrl_q;
  logic           armed_q, fast_q, cs_n_q;

  // named internal events
  logic accept_ctrl, accept_pdata;
  logic [2:0] mode_in;

  assign mode_in      = wr_val[6:4];
  assign busy         = (st_q == SQ_CMD) || (st_q == SQ_RESP) ||
                        (st_q == SQ_POP) || (st_q == SQ_PDATA);
  assign accept_ctrl  = ctrl_wr && !busy;
  assign accept_pdata = pdata_wr && !busy && armed_q;
  assign idx_n        = idx_q + 3'd1;

  function automatic logic [7:0] tx_at(input logic [NUM_TX*8-1:0] f, input logic [2:0] k);
    logic [7:0] b;
    b = 8'h00;
    for (int i = 0; i < NUM_TX; i++)
      if (k == 3'(i)) b = f[i*8 +: 8];
    return b;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SQ_IDLE; idx_q <= '0; nwr_q <= '0; nrd_q <= '0;
      pg_cnt_q <= '0; pend_q <= '0; ctrl_q <= '0;
      armed_q <= 1'b0; fast_q <= 1'b0; cs_n_q <= 1'b1;
      sh_start <= 1'b0; sh_byte <= '0;
    end else begin
      sh_start <= 1'b0;
      if (accept_ctrl) begin
        ctrl_q <= wr_val[6:0];
        if (st_q == SQ_PWAIT) begin
          cs_n_q  <= 1'b1;
          armed_q <= 1'b0;
          st_q    <= SQ_IDLE;
        end else if (is_cmd_mode(mode_in)) begin
          fast_q   <= mode_in[0];
          nwr_q    <= wr_count(wr_val[1:0]);
          nrd_q    <= wr_val[3:2];
          idx_q    <= '0;
          cs_n_q   <= 1'b0;
          armed_q  <= 1'b0;
          st_q     <= SQ_CMD;
          sh_start <= 1'b1;
          sh_byte  <= tx_at(tx_flat, 3'd0);
        end else if (is_page_mode(mode_in)) begin
          armed_q <= 1'b1;
          fast_q  <= mode_in[0];
        end else begin
          armed_q <= 1'b0;
        end
      end else if (accept_pdata) begin
        sh_start <= 1'b1;
        if (st_q == SQ_IDLE) begin
          pend_q   <= wr_val;
          pg_cnt_q <= '0;
          cs_n_q   <= 1'b0;
          sh_byte  <= tx_at(tx_flat, 3'd0);
          st_q     <= SQ_POP;
        end else begin
          sh_byte <= wr_val;
          st_q    <= SQ_PDATA;
        end
      end else begin
        case (st_q)
          SQ_CMD: if (sh_done) begin
            if (idx_n == nwr_q) begin
              idx_q <= '0;
              if (nrd_q == 2'd0) begin
                cs_n_q <= 1'b1;
                st_q   <= SQ_IDLE;
              end else begin
                st_q     <= SQ_RESP;
                sh_start <= 1'b1;
                sh_byte  <= 8'h00;
              end
            end else begin
              idx_q    <= idx_n;
              sh_start <= 1'b1;
              sh_byte  <= tx_at(tx_flat, idx_n);
            end
          end
          SQ_RESP: if (sh_done) begin
            if (idx_n == {1'b0, nrd_q}) begin
              cs_n_q <= 1'b1;
              st_q   <= SQ_IDLE;
            end else begin
              idx_q    <= idx_n;
              sh_start <= 1'b1;
              sh_byte  <= 8'h00;
            end
          end
          SQ_POP: if (sh_done) begin
            sh_start <= 1'b1;
            sh_byte  <= pend_q;
            st_q     <= SQ_PDATA;
          end
          SQ_PDATA: if (sh_done) begin
            pg_cnt_q <= pg_cnt_q + 1'b1;
            if (pg_cnt_q + 1'b1 == PCW'(PAGE_BYTES)) begin
              cs_n_q  <= 1'b1;
              armed_q <= 1'b0;
              st_q    <= SQ_IDLE;
            end else begin
              st_q <= SQ_PWAIT;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rx_we     = (st_q == SQ_RESP) && sh_done;
  assign rx_idx    = idx_q[1:0];
  assign rx_byte   = sh_rx;
  assign fast      = fast_q;
  assign cs_n      = cs_n_q;
  assign ctrl_bits = ctrl_q;

  assert_busy_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_ctrl && is_cmd_mode(mode_in) && (st_q != SQ_PWAIT)) |=> busy);
  assert_ignore_busy_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && busy) |=> $stable(ctrl_q));
  assert_cs_during_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cs_n_q);
  assert_page_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pg_cnt_q <= PCW'(PAGE_BYTES));
  assert_rx_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_we |-> (idx_q < {1'b0, nrd_q}));
  assert_close_session_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_ctrl && (st_q == SQ_PWAIT)) |=> (cs_n_q && !busy && !armed_q));

endmodule

// File: rtl/spi_flash_cmd_engine.sv
module spi_flash_cmd_engine
  import spi_eng_pkg::*;
#(
  parameter int FAST_HALF  = 3,
  parameter int SLOW_HALF  = 6,
  parameter int PAGE_BYTES = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [3:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [3:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       spi_sck,
  output logic       spi_cs_n,
  output logic       spi_mosi,
  input  logic       spi_miso
);
  logic [7:0]          tx_q [NUM_TX];
  logic [7:0]          rx_q [NUM_RX];
  logic [NUM_TX*8-1:0] tx_flat;

  logic       busy, fast, tick, sh_active, sh_done, sh_start;
  logic [7:0] sh_byte, sh_rx, rx_byte;
  logic [6:0] ctrl_bits;
  logic       rx_we;
  logic [1:0] rx_idx;
  logic       ctrl_wr, pdata_wr;

  assign ctrl_wr  = wr_en && (wr_addr == OFS_CTRL);
  assign pdata_wr = wr_en && (wr_addr == OFS_PDATA);

  for (genvar i = 0; i < NUM_TX; i++) begin : g_tx
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tx_q[i] <= '0;
      else if (wr_en && !busy && (wr_addr == OFS_TX0 + 4'(i))) tx_q[i] <= wr_data;
    end
    assign tx_flat[i*8 +: 8] = tx_q[i];
  end

  for (genvar j = 0; j < NUM_RX; j++) begin : g_rx
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rx_q[j] <= '0;
      else if (rx_we && (rx_idx == 2'(j))) rx_q[j] <= rx_byte;
    end
  end

  always_comb begin
    rd_data = 8'h00;
    if (rd_addr == OFS_CTRL) rd_data = {busy, ctrl_bits};
    for (int i = 0; i < NUM_TX; i++)
      if (rd_addr == OFS_TX0 + 4'(i)) rd_data = tx_q[i];
    for (int j = 0; j < NUM_RX; j++)
      if (rd_addr == OFS_RX0 + 4'(j)) rd_data = rx_q[j];
  end

  spi_eng_seq #(.PAGE_BYTES(PAGE_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .pdata_wr(pdata_wr),
    .wr_val(wr_data), .tx_flat(tx_flat), .sh_done(sh_done), .sh_rx(sh_rx),
    .sh_start(sh_start), .sh_byte(sh_byte), .fast(fast), .busy(busy),
    .cs_n(spi_cs_n), .ctrl_bits(ctrl_bits), .rx_we(rx_we), .rx_idx(rx_idx),
    .rx_byte(rx_byte)
  );

  spi_eng_clkgen #(.FAST_HALF(FAST_HALF), .SLOW_HALF(SLOW_HALF)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(sh_active), .fast(fast), .tick(tick)
  );

  spi_eng_shifter u_sh (
    .clk(clk), .rst_n(rst_n), .start(sh_start), .tx_byte(sh_byte), .tick(tick),
    .miso(spi_miso), .sck(spi_sck), .mosi(spi_mosi), .active(sh_active),
    .done(sh_done), .rx_byte(sh_rx)
  );

  assert_sck_within_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sck |-> !spi_cs_n);
  assert_speed_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sh_active |-> $stable(fast));

endmodule

// File: tb/spi_flash_cmd_engine_tb_top.sv
`timescale 1ns/1ps
module spi_flash_cmd_engine_tb_top;
  localparam real CLK_NS = 5.0;
  localparam int  FASTH = 3;
  localparam int  SLOWH = 6;
  localparam int  PAGE  = 256;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       spi_sck, spi_cs_n, spi_mosi, spi_miso;

  always #2.5 clk = ~clk;

  spi_flash_cmd_engine dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] resp(input int i);
    return 8'(32'hC3 ^ (i * 37));
  endfunction

  function automatic int nbytes(input logic [1:0] code);
    if (code == 2'd0) return 1;
    if (code == 2'd1) return 2;
    if (code == 2'd2) return 4;
    return 5;
  endfunction

  // scoreboard queues, filled by the driver
  logic [7:0] exp_q[$];
  int         len_q[$];
  int         half_q[$];

  // monitor: flash slave model
  logic [7:0] sl_rx = '0, sl_tx = '0;
  int  bcnt = 0, bidx = 0, cur_len = 0, cur_half = 0, frames = 0;
  bit  in_frame = 1'b0;
  realtime last_rise = 0.0;
  assign spi_miso = sl_tx[7];

  always @(negedge spi_cs_n) begin
    frames++;
    in_frame = 1'b1;
    bcnt = 0; bidx = 0; sl_tx = resp(0);
    if (len_q.size() == 0) begin
      chk(1'b0, "R6 unexpected frame", frames, 0);
      cur_len = 0; cur_half = FASTH;
    end else begin
      cur_len = len_q.pop_front();
      cur_half = half_q.pop_front();
    end
  end

  always @(posedge spi_cs_n) begin
    if (in_frame) begin
      in_frame = 1'b0;
      chk(bidx == cur_len && bcnt == 0, "R6 frame length", bidx, cur_len);
    end
  end

  always @(posedge spi_sck) begin
    realtime d, e;
    if (spi_cs_n) chk(1'b0, "R6 sck outside cs", 1, 0);
    if (bcnt > 0) begin
      d = $realtime - last_rise;
      e = 2.0 * cur_half * CLK_NS;
      chk(d > e - 0.5 && d < e + 0.5, "R5 sck period", int'(d), int'(e));
    end
    last_rise = $realtime;
    sl_rx = {sl_rx[6:0], spi_mosi};
    bcnt++;
    if (bcnt == 8) begin
      if (exp_q.size() == 0) chk(1'b0, "R3 extra byte", sl_rx, 0);
      else begin
        logic [7:0] ex;
        ex = exp_q.pop_front();
        chk(sl_rx == ex, "R3/R4/R8 mosi byte", sl_rx, ex);
      end
      bcnt = 0;
      bidx++;
    end
  end

  always @(negedge spi_sck) begin
    if (!spi_cs_n) begin
      if (bcnt == 0) sl_tx = resp(bidx);
      else           sl_tx = {sl_tx[6:0], 1'b0};
    end
  end

  // driver tasks
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    rd_addr = a; #0.1; d = rd_data;
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk); rd(4'd0, v);
      if (!v[7]) return;
    end
    chk(1'b0, "R2 busy never cleared", 1, 0);
  endtask

  task automatic run_cmd(input logic [1:0] code, input logic [1:0] nrd, input bit fast,
                         input logic [39:0] bytes);
    logic [7:0] v, c;
    int n;
    n = nbytes(code);
    for (int k = 0; k < 5; k++) wr(4'(k + 1), bytes[k*8 +: 8]);
    for (int k = 0; k < n; k++) exp_q.push_back(bytes[k*8 +: 8]);
    for (int k = 0; k < int'(nrd); k++) exp_q.push_back(8'h00);
    len_q.push_back(n + int'(nrd));
    half_q.push_back(fast ? FASTH : SLOWH);
    c = {1'b0, (fast ? 3'd5 : 3'd4), nrd, code};
    wr(4'd0, c);
    rd(4'd0, v);
    chk(v[7] == 1'b1, "R2 busy after start", v, 8'h80 | c);
    wait_idle();
    chk(spi_cs_n == 1'b1, "R6 cs high after cmd", spi_cs_n, 1);
    rd(4'd0, v);
    chk(v == c, "R2 control readback", v, c);
    for (int k = 0; k < int'(nrd); k++) begin
      rd(4'(6 + k), v);
      chk(v == resp(n + k), "R4 response byte", v, resp(n + k));
    end
    for (int k = 0; k < 5; k++) begin
      rd(4'(k + 1), v);
      chk(v == bytes[k*8 +: 8], "R3 tx readback", v, bytes[k*8 +: 8]);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin : main
    logic [7:0] v;
    int f0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'd0, v); chk(v == 8'h00, "R1 ctrl reset", v, 0);
    chk(spi_cs_n == 1'b1, "R1 cs reset", spi_cs_n, 1);
    chk(spi_sck == 1'b0, "R1 sck reset", spi_sck, 0);
    for (int k = 0; k < 3; k++) begin
      rd(4'(6 + k), v); chk(v == 8'h00, "R1 rx reset", v, 0);
    end

    // R2 R3 R4 R5: several command shapes
    run_cmd(2'd0, 2'd3, 1'b1, 40'h00_00_00_00_9F);
    run_cmd(2'd2, 2'd2, 1'b0, 40'h00_56_34_12_03);
    run_cmd(2'd3, 2'd0, 1'b1, 40'hA5_30_20_10_02);
    run_cmd(2'd1, 2'd1, 1'b0, 40'h00_00_00_3C_01);

    // R7: writes during a busy transaction are ignored
    for (int k = 0; k < 5; k++) wr(4'(k + 1), 8'(8'h40 + k));
    for (int k = 0; k < 5; k++) exp_q.push_back(8'(8'h40 + k));
    for (int k = 0; k < 3; k++) exp_q.push_back(8'h00);
    len_q.push_back(8); half_q.push_back(SLOWH);
    f0 = frames;
    wr(4'd0, 8'h4F);
    wr(4'd0, 8'h51);
    wr(4'd2, 8'hEE);
    wait_idle();
    rd(4'd0, v); chk(v == 8'h4F, "R7 ctrl write while busy", v, 8'h4F);
    rd(4'd2, v); chk(v == 8'h41, "R7 tx write while busy", v, 8'h41);
    chk(frames == f0 + 1, "R7 single frame", frames - f0, 1);

    // R11: non-start modes and 0x20
    f0 = frames;
    wr(4'd0, 8'h10); wr(4'd0, 8'h75); wr(4'd0, 8'h00);
    wr(4'd0, 8'h20);
    repeat (50) @(negedge clk);
    rd(4'd0, v); chk(v[7] == 1'b0, "R11 busy after 0x20", v, 8'h20);
    chk(spi_cs_n == 1'b1, "R11 cs after 0x20", spi_cs_n, 1);
    chk(frames == f0, "R11 no frame started", frames - f0, 0);

    // R9: data port while not armed
    wr(4'd0, 8'h00);
    wr(4'd9, 8'h77);
    repeat (100) @(negedge clk);
    chk(frames == f0, "R9 data write not armed", frames - f0, 0);

    // R8 fast page program, with a data write while busy (R9)
    wr(4'd1, 8'h02);
    wr(4'd0, 8'h30);
    repeat (20) @(negedge clk);
    chk(spi_cs_n == 1'b1, "R8 arm without bus activity", spi_cs_n, 1);
    chk(frames == f0, "R8 no frame on arm", frames - f0, 0);
    len_q.push_back(PAGE + 1); half_q.push_back(FASTH);
    exp_q.push_back(8'h02);
    for (int k = 0; k < PAGE; k++) begin
      exp_q.push_back(8'(k * 7 + 1));
      wr(4'd9, 8'(k * 7 + 1));
      if (k == 10) wr(4'd9, 8'hFF);
      wait_idle();
      if (k == PAGE - 2) chk(spi_cs_n == 1'b0, "R8 cs held in page", spi_cs_n, 0);
    end
    chk(spi_cs_n == 1'b1, "R8 cs after page", spi_cs_n, 1);
    chk(frames == f0 + 1, "R8 one page frame", frames - f0, 1);
    wr(4'd9, 8'h55);
    repeat (100) @(negedge clk);
    chk(frames == f0 + 1, "R8 disarmed after page", frames - f0, 1);

    // R10: control write closes an open slow page session
    wr(4'd1, 8'h9F);
    wr(4'd0, 8'h20);
    len_q.push_back(4); half_q.push_back(SLOWH);
    exp_q.push_back(8'h9F);
    for (int k = 0; k < 3; k++) begin
      exp_q.push_back(8'(8'h11 * (k + 1)));
      wr(4'd9, 8'(8'h11 * (k + 1)));
      wait_idle();
    end
    chk(spi_cs_n == 1'b0, "R10 session open", spi_cs_n, 0);
    f0 = frames;
    wr(4'd0, 8'h51);
    rd(4'd0, v); chk(v[7] == 1'b0, "R10 busy after close", v, 0);
    chk(spi_cs_n == 1'b1, "R10 cs after close", spi_cs_n, 1);
    wr(4'd9, 8'h44);
    repeat (200) @(negedge clk);
    chk(frames == f0, "R10 data ignored after close", frames - f0, 0);

    chk(exp_q.size() == 0, "R3 all bytes seen", exp_q.size(), 0);
    chk(len_q.size() == 0, "R6 all frames seen", len_q.size(), 0);
    finish_run();
  end
endmodule